// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a 32-bit virtual address to a physical page frame when the translation cache misses. On an accepted request it picks the segment table base frame for the requesting mode (user or supervisor) and reads one segment entry from memory. If that entry is well formed, it then reads one page entry from the page table page that the segment entry names. It returns the physical frame, a cache-inhibit flag and a read-only flag, or one of three fault codes.

On a successful walk the page entry's reference bit is set, and its modify bit is also set for a write. The updated entry is written back to the same address, but only when one of those two bits actually changes. Memory is reached through one request port. A request is held until a one-cycle acknowledge, and read data arrives with that acknowledge. The translation cache, control registers and bus arbitration sit outside this block.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `busy`, `done`, `mem_req` and `mem_we` are all 0.
- R2: The first read of a walk goes to address (base << 12) + VA[31:22]*4. The base is `user_base` when `req_user` is 1 and `sup_base` otherwise. Both are sampled when the request is accepted.
- R3: The second read goes to address (segment entry bits 31:12 << 12) + VA[21:12]*4.
- R4: A segment entry is valid only when bits 11:4 are zero and bit 3 is one. An invalid segment entry ends the walk with `resp_fault` = 1 (table fault) and no page entry read.
- R5: A page entry is valid only when bit 5 is zero, whatever bits 11:7 hold. An invalid page entry ends the walk with `resp_fault` = 2 (page fault) and no write-back.
- R6: A write to a page whose segment bit 2 or page bit 2 is one ends the walk with `resp_fault` = 3 (protection fault) and `resp_ro` = 1. The page entry is not written back.
- R7: On success `resp_fault` = 0, `resp_frame` = page entry bits 31:12, `resp_cinh` = page entry bit 6, and `resp_ro` = segment bit 2 OR page bit 2. On any fault `resp_frame` and `resp_cinh` are 0.
- R8: On success the page entry is written back to its own address with bit 3 set, bit 4 also set for a write, and all other bits kept. No write occurs when these bits already hold those values.
- R9: Each accepted request gives exactly one one-cycle `done` pulse. `req_valid` while `busy` is 1 is ignored and causes no memory traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a walk (taken when not busy) |
| req_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| req_va | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| user_base | input | 20 | User segment table frame number |
| sup_base | input | 20 | Supervisor segment table frame number |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write-back |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Write-back data |
| mem_ack | input | 1 | One-cycle acknowledge |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle result strobe |
| resp_frame | output | 20 | Physical frame number |
| resp_cinh | output | 1 | Cache inhibit |
| resp_ro | output | 1 | Read-only |
| resp_fault | output | 2 | 0 none, 1 table, 2 page, 3 protection |

## Verification
A latched base, index or segment frame that is wrong shows up at once in `mem_addr` on the first or second read, in the cycle the request is raised. A wrong validity or protection decision shows up in `resp_fault` one cycle after the acknowledge that carried the entry. It also shows up as an extra or missing read or write-back in the memory traffic. A write-back that builds its data wrongly leaves the stored entry wrong, and the bench checks the stored entry after each walk. A state machine that does not return to idle shows up as a missing `done` pulse or as a later request being dropped.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W      = 32;
  localparam int PAGE_BITS = 12;
  localparam int IDX_W     = 10;
  localparam int ENT_LOG   = 2;
  localparam int FRAME_W   = VA_W - PAGE_BITS;

  localparam int RO_BIT    = 2;
  localparam int MARK_BIT  = 3;
  localparam int REF_BIT   = 3;
  localparam int MOD_BIT   = 4;
  localparam int PRSV_BIT  = 5;
  localparam int CI_BIT    = 6;
  localparam int SZERO_LO  = 4;
  localparam int SZERO_HI  = PAGE_BITS - 1;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_TABLE = 2'd1,
    FLT_PAGE  = 2'd2,
    FLT_PROT  = 2'd3
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SEG, ST_PG, ST_WB, ST_RESP
  } walk_st_e;

  function automatic logic [VA_W-1:0] entry_addr(input logic [FRAME_W-1:0] frame,
                                                 input logic [IDX_W-1:0] idx);
    return {frame, idx, {ENT_LOG{1'b0}}};
  endfunction

  function automatic logic seg_ok(input logic [VA_W-1:0] e);
    return (e[SZERO_HI:SZERO_LO] == '0) && e[MARK_BIT];
  endfunction

  function automatic logic pg_ok(input logic [VA_W-1:0] e);
    return !e[PRSV_BIT];
  endfunction

  function automatic logic [VA_W-1:0] pg_touch(input logic [VA_W-1:0] e, input logic wr);
    logic [VA_W-1:0] n;
    n = e;
    n[REF_BIT] = 1'b1;
    if (wr) n[MOD_BIT] = 1'b1;
    return n;
  endfunction
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
(
  input  logic               req_user,
  input  logic [FRAME_W-1:0] user_base,
  input  logic [FRAME_W-1:0] sup_base,
  input  logic [FRAME_W-1:0] lat_base,
  input  logic [VA_W-1:0]    lat_va,
  input  logic [FRAME_W-1:0] lat_seg_frame,
  output logic [FRAME_W-1:0] base_sel,
  output logic [VA_W-1:0]    seg_addr,
  output logic [VA_W-1:0]    pg_addr
);
  localparam int SEG_LO = PAGE_BITS + IDX_W;

  wire unused_offset = ^lat_va[PAGE_BITS-1:0];

  assign base_sel = req_user ? user_base : sup_base;
  assign seg_addr = entry_addr(lat_base, lat_va[VA_W-1:SEG_LO]);
  assign pg_addr  = entry_addr(lat_seg_frame, lat_va[SEG_LO-1:PAGE_BITS]);
endmodule

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode
  import ptw_pkg::*;
(
  input  logic [VA_W-1:0]    entry,
  input  logic               is_write,
  output logic               seg_valid,
  output logic               pg_valid,
  output logic               ent_ro,
  output logic               ent_ci,
  output logic [FRAME_W-1:0] ent_frame,
  output logic [VA_W-1:0]    wb_data,
  output logic               wb_needed
);
  assign seg_valid = seg_ok(entry);
  assign pg_valid  = pg_ok(entry);
  assign ent_ro    = entry[RO_BIT];
  assign ent_ci    = entry[CI_BIT];
  assign ent_frame = entry[VA_W-1:PAGE_BITS];
  assign wb_data   = pg_touch(entry, is_write);
  assign wb_needed = (wb_data != entry);
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [VA_W-1:0]    req_va,
  input  logic               req_write,
  input  logic [FRAME_W-1:0] base_sel,
  input  logic [VA_W-1:0]    seg_addr,
  input  logic [VA_W-1:0]    pg_addr,
  input  logic               mem_ack,
  input  logic               seg_valid,
  input  logic               pg_valid,
  input  logic               ent_ro,
  input  logic               ent_ci,
  input  logic [FRAME_W-1:0] ent_frame,
  input  logic [VA_W-1:0]    wb_data,
  input  logic               wb_needed,
  output logic [FRAME_W-1:0] lat_base,
  output logic [VA_W-1:0]    lat_va,
  output logic               lat_write,
  output logic [FRAME_W-1:0] lat_seg_frame,
  output logic               mem_req,
  output logic               mem_we,
  output logic [VA_W-1:0]    mem_addr,
  output logic [VA_W-1:0]    mem_wdata,
  output logic               busy,
  output logic               done,
  output logic [FRAME_W-1:0] resp_frame,
  output logic               resp_cinh,
  output logic               resp_ro,
  output fault_e             resp_fault,
  output logic               evt_accept,
  output logic               evt_seg_bad,
  output logic               evt_pg_bad,
  output logic               evt_prot
);
  walk_st_e        state;
  logic            seg_ro;
  logic [VA_W-1:0] wb_q;
  logic            ro_any;

  assign ro_any      = seg_ro | ent_ro;
  assign evt_accept  = (state == ST_IDLE) && req_valid;
  assign evt_seg_bad = (state == ST_SEG) && mem_ack && !seg_valid;
  assign evt_pg_bad  = (state == ST_PG) && mem_ack && !pg_valid;
  assign evt_prot    = (state == ST_PG) && mem_ack && pg_valid && lat_write && ro_any;

  assign mem_req   = (state == ST_SEG) || (state == ST_PG) || (state == ST_WB);
  assign mem_we    = (state == ST_WB);
  assign mem_addr  = (state == ST_SEG) ? seg_addr : pg_addr;
  assign mem_wdata = wb_q;
  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_RESP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      lat_base      <= '0;
      lat_va        <= '0;
      lat_write     <= 1'b0;
      lat_seg_frame <= '0;
      seg_ro        <= 1'b0;
      wb_q          <= '0;
      resp_frame    <= '0;
      resp_cinh     <= 1'b0;
      resp_ro       <= 1'b0;
      resp_fault    <= FLT_NONE;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            lat_base  <= base_sel;
            lat_va    <= req_va;
            lat_write <= req_write;
            state     <= ST_SEG;
          end
        end
        ST_SEG: begin
          if (mem_ack) begin
            if (!seg_valid) begin
              resp_frame <= '0;
              resp_cinh  <= 1'b0;
              resp_ro    <= 1'b0;
              resp_fault <= FLT_TABLE;
              state      <= ST_RESP;
            end else begin
              lat_seg_frame <= ent_frame;
              seg_ro        <= ent_ro;
              state         <= ST_PG;
            end
          end
        end
        ST_PG: begin
          if (mem_ack) begin
            if (!pg_valid) begin
              resp_frame <= '0;
              resp_cinh  <= 1'b0;
              resp_ro    <= 1'b0;
              resp_fault <= FLT_PAGE;
              state      <= ST_RESP;
            end else if (lat_write && ro_any) begin
              resp_frame <= '0;
              resp_cinh  <= 1'b0;
              resp_ro    <= 1'b1;
              resp_fault <= FLT_PROT;
              state      <= ST_RESP;
            end else begin
              resp_frame <= ent_frame;
              resp_cinh  <= ent_ci;
              resp_ro    <= ro_any;
              resp_fault <= FLT_NONE;
              wb_q       <= wb_data;
              state      <= wb_needed ? ST_WB : ST_RESP;
            end
          end
        end
        ST_WB:   if (mem_ack) state <= ST_RESP;
        ST_RESP: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_user,
  input  logic [VA_W-1:0]    req_va,
  input  logic               req_write,
  input  logic [FRAME_W-1:0] user_base,
  input  logic [FRAME_W-1:0] sup_base,
  output logic               mem_req,
  output logic               mem_we,
  output logic [VA_W-1:0]    mem_addr,
  output logic [VA_W-1:0]    mem_wdata,
  input  logic               mem_ack,
  input  logic [VA_W-1:0]    mem_rdata,
  output logic               busy,
  output logic               done,
  output logic [FRAME_W-1:0] resp_frame,
  output logic               resp_cinh,
  output logic               resp_ro,
  output logic [1:0]         resp_fault
);
  logic [FRAME_W-1:0] base_sel, lat_base, lat_seg_frame, ent_frame;
  logic [VA_W-1:0]    lat_va, seg_addr, pg_addr, wb_data;
  logic               lat_write, seg_valid, pg_valid, ent_ro, ent_ci, wb_needed;
  logic               evt_accept, evt_seg_bad, evt_pg_bad, evt_prot;
  fault_e             fault_q;

  assign resp_fault = fault_q;

  ptw_addr_gen u_addr (
    .req_user(req_user), .user_base(user_base), .sup_base(sup_base),
    .lat_base(lat_base), .lat_va(lat_va), .lat_seg_frame(lat_seg_frame),
    .base_sel(base_sel), .seg_addr(seg_addr), .pg_addr(pg_addr)
  );

  ptw_entry_decode u_dec (
    .entry(mem_rdata), .is_write(lat_write),
    .seg_valid(seg_valid), .pg_valid(pg_valid), .ent_ro(ent_ro), .ent_ci(ent_ci),
    .ent_frame(ent_frame), .wb_data(wb_data), .wb_needed(wb_needed)
  );

  ptw_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
    .req_write(req_write), .base_sel(base_sel), .seg_addr(seg_addr), .pg_addr(pg_addr),
    .mem_ack(mem_ack), .seg_valid(seg_valid), .pg_valid(pg_valid), .ent_ro(ent_ro),
    .ent_ci(ent_ci), .ent_frame(ent_frame), .wb_data(wb_data), .wb_needed(wb_needed),
    .lat_base(lat_base), .lat_va(lat_va), .lat_write(lat_write),
    .lat_seg_frame(lat_seg_frame), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy), .done(done),
    .resp_frame(resp_frame), .resp_cinh(resp_cinh), .resp_ro(resp_ro),
    .resp_fault(fault_q), .evt_accept(evt_accept), .evt_seg_bad(evt_seg_bad),
    .evt_pg_bad(evt_pg_bad), .evt_prot(evt_prot)
  );
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_ack,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        done,
  input logic        busy,
  input logic        resp_ro,
  input logic [1:0]  resp_fault,
  input logic        evt_seg_bad,
  input logic        evt_pg_bad,
  input logic        evt_prot
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R2
  AST_SEG_BAD_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    evt_seg_bad |=> (done && resp_fault == 2'd1 && !mem_req)); // R4
  AST_PG_BAD_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pg_bad |=> (done && resp_fault == 2'd2 && !mem_we)); // R5
  AST_PROT_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    evt_prot |=> (done && resp_fault == 2'd3 && resp_ro)); // R6
  AST_WB_HAS_REF: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_wdata[3]); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy)); // R9
endmodule

bind ptw_walker ptw_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .done(done), .busy(busy),
  .resp_ro(resp_ro), .resp_fault(resp_fault), .evt_seg_bad(evt_seg_bad),
  .evt_pg_bad(evt_pg_bad), .evt_prot(evt_prot)
);

// File: tb/ptw_walker_tb.sv
`timescale 1ns/1ps
module ptw_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_user = 1'b0, req_write = 1'b0;
  logic [31:0] req_va = '0;
  logic [19:0] user_base = 20'h1, sup_base = 20'h3;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        busy, done, resp_cinh, resp_ro;
  logic [19:0] resp_frame;
  logic [1:0]  resp_fault;

  int n_chk = 0, n_fail = 0;
  int rd_cnt = 0, wr_cnt = 0, done_cnt = 0;
  logic [31:0] rd_prev = '0, rd_last = '0, wr_addr = '0;
  logic [31:0] mem [0:8191];

  always #2.5 clk = ~clk;

  ptw_walker u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_user(req_user),
    .req_va(req_va), .req_write(req_write), .user_base(user_base), .sup_base(sup_base),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .resp_frame(resp_frame), .resp_cinh(resp_cinh), .resp_ro(resp_ro),
    .resp_fault(resp_fault)
  );

  initial begin mem_ack = 1'b0; mem_rdata = '0; end

  always @(posedge clk) begin
    if (!rst_n) mem_ack <= 1'b0;
    else begin
      mem_ack <= 1'b0;
      if (done) done_cnt <= done_cnt + 1;
      if (mem_req && !mem_ack) begin
        mem_ack <= 1'b1;
        if (mem_we) begin
          mem[mem_addr[14:2]] <= mem_wdata;
          wr_cnt  <= wr_cnt + 1;
          wr_addr <= mem_addr;
        end else begin
          mem_rdata <= mem[mem_addr[14:2]];
          rd_prev   <= rd_last;
          rd_last   <= mem_addr;
          rd_cnt    <= rd_cnt + 1;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic setw(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    mem[a[14:2]] <= d;
  endtask

  task automatic walk(input logic usr, input logic [31:0] va, input logic wr);
    int t;
    @(negedge clk);
    req_user = usr; req_va = va; req_write = wr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (!done && t < 100) begin @(negedge clk); t++; end
    chk("R9 done seen", {31'b0, done}, 32'd1);
  endtask

  task automatic chk_resp(input string tag, input logic [1:0] f, input logic [19:0] fr,
                          input logic ci, input logic ro);
    chk({tag, " fault"}, {30'b0, resp_fault}, {30'b0, f});
    chk({tag, " frame"}, {12'b0, resp_frame}, {12'b0, fr});
    chk({tag, " cinh"},  {31'b0, resp_cinh}, {31'b0, ci});
    chk({tag, " ro"},    {31'b0, resp_ro},   {31'b0, ro});
  endtask

  task automatic t_reset;
    chk("R1 busy", {31'b0, busy}, 32'd0);
    chk("R1 done", {31'b0, done}, 32'd0);
    chk("R1 mem_req", {31'b0, mem_req}, 32'd0);
    chk("R1 mem_we", {31'b0, mem_we}, 32'd0);
  endtask

  task automatic t_user_read;
    int r0, w0;
    setw(32'h1014, 32'h0000_4008);
    setw(32'h4028, 32'h1234_5000);
    r0 = rd_cnt; w0 = wr_cnt;
    walk(1'b1, {10'h005, 10'h00A, 12'h123}, 1'b0);
    chk("R2 user seg addr", rd_prev, 32'h1014);
    chk("R3 page addr", rd_last, 32'h4028);
    chk_resp("R7 user read", 2'd0, 20'h12345, 1'b0, 1'b0);
    chk("R8 ref wb count", wr_cnt - w0, 32'd1);
    chk("R8 ref wb addr", wr_addr, 32'h4028);
    chk("R8 ref wb data", mem[32'h4028 >> 2], 32'h1234_5008);
    chk("R9 read count", rd_cnt - r0, 32'd2);
    @(negedge clk);
    chk("R9 done one cycle", {31'b0, done}, 32'd0);
  endtask

  task automatic t_sup_write;
    int w0;
    setw(32'h3FFC, 32'h0000_5008);
    setw(32'h5FFC, 32'hCAFE_BFC0);
    w0 = wr_cnt;
    walk(1'b0, {10'h3FF, 10'h3FF, 12'hABC}, 1'b1);
    chk("R2 sup seg addr", rd_prev, 32'h3FFC);
    chk("R3 page addr hi", rd_last, 32'h5FFC);
    chk_resp("R7 sup write", 2'd0, 20'hCAFEB, 1'b1, 1'b0);
    chk("R8 mod wb count", wr_cnt - w0, 32'd1);
    chk("R8 mod wb data", mem[32'h5FFC >> 2], 32'hCAFE_BFD8);
  endtask

  task automatic t_no_wb;
    int w0;
    setw(32'h1018, 32'h0000_4008);
    setw(32'h4004, 32'h0077_7008);
    setw(32'h4008, 32'h0088_8018);
    w0 = wr_cnt;
    walk(1'b1, {10'h006, 10'h001, 12'h0}, 1'b0);
    chk_resp("R7 ref preset", 2'd0, 20'h00777, 1'b0, 1'b0);
    chk("R8 no wb on read", wr_cnt - w0, 32'd0);
    walk(1'b1, {10'h006, 10'h002, 12'h0}, 1'b1);
    chk_resp("R7 mod preset", 2'd0, 20'h00888, 1'b0, 1'b0);
    chk("R8 no wb on write", wr_cnt - w0, 32'd0);
  endtask

  task automatic t_seg_bad;
    int r0, w0;
    setw(32'h101C, 32'h0000_4000);
    setw(32'h1020, 32'h0000_4018);
    r0 = rd_cnt; w0 = wr_cnt;
    walk(1'b1, {10'h007, 10'h000, 12'h0}, 1'b0);
    chk_resp("R4 mark clear", 2'd1, 20'h0, 1'b0, 1'b0);
    chk("R4 one read", rd_cnt - r0, 32'd1);
    walk(1'b1, {10'h008, 10'h000, 12'h0}, 1'b0);
    chk_resp("R4 zero field set", 2'd1, 20'h0, 1'b0, 1'b0);
    chk("R4 reads total", rd_cnt - r0, 32'd2);
    chk("R4 no write", wr_cnt - w0, 32'd0);
  endtask

  task automatic t_pg_bad;
    int w0;
    setw(32'h1024, 32'h0000_4008);
    setw(32'h400C, 32'h0099_9060);
    w0 = wr_cnt;
    walk(1'b1, {10'h009, 10'h003, 12'h0}, 1'b0);
    chk_resp("R5 reserved set", 2'd2, 20'h0, 1'b0, 1'b0);
    chk("R5 no write", wr_cnt - w0, 32'd0);
    chk("R5 entry kept", mem[32'h400C >> 2], 32'h0099_9060);
  endtask

  task automatic t_prot;
    int w0;
    setw(32'h1028, 32'h0000_400C);
    setw(32'h4010, 32'h00AA_A000);
    setw(32'h102C, 32'h0000_4008);
    setw(32'h4014, 32'h00BB_B00C);
    w0 = wr_cnt;
    walk(1'b1, {10'h00A, 10'h004, 12'h0}, 1'b1);
    chk_resp("R6 seg ro write", 2'd3, 20'h0, 1'b0, 1'b1);
    chk("R6 no write", wr_cnt - w0, 32'd0);
    chk("R6 entry kept", mem[32'h4010 >> 2], 32'h00AA_A000);
    walk(1'b1, {10'h00B, 10'h005, 12'h0}, 1'b1);
    chk_resp("R6 page ro write", 2'd3, 20'h0, 1'b0, 1'b1);
    chk("R6 no write 2", wr_cnt - w0, 32'd0);
    walk(1'b1, {10'h00A, 10'h004, 12'h0}, 1'b0);
    chk_resp("R7 seg ro read", 2'd0, 20'h00AAA, 1'b0, 1'b1);
    chk("R8 ro read wb", mem[32'h4010 >> 2], 32'h00AA_A008);
  endtask

  task automatic t_busy_ignore;
    int r0, d0, t;
    setw(32'h1030, 32'h0000_4008);
    setw(32'h4018, 32'h00CC_C008);
    r0 = rd_cnt; d0 = done_cnt;
    @(negedge clk);
    req_user = 1'b1; req_va = {10'h00C, 10'h006, 12'h0}; req_write = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    req_va = {10'h005, 10'h00A, 12'h0}; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (!done && t < 100) begin @(negedge clk); t++; end
    chk_resp("R9 first wins", 2'd0, 20'h00CCC, 1'b0, 1'b0);
    repeat (6) @(negedge clk);
    chk("R9 one done", done_cnt - d0, 32'd1);
    chk("R9 two reads", rd_cnt - r0, 32'd2);
  endtask

  initial begin
    #(5ns * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_user_read();
    t_sup_write();
    t_no_wb();
    t_seg_bad();
    t_pg_bad();
    t_prot();
    t_busy_ignore();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule